// File: doc/BRIEF.md
# Smart-Card Character Transmitter with Automatic Retry

This block sends characters over the single bidirectional data line of a contact smart card, using asynchronous character framing. A character is a low start bit, eight data bits sent least significant bit first, and an even parity bit. These are followed by a guard period during which the transmitter releases the line. The line is open-drain: the block only ever pulls it low, and an external pull-up gives the high level. Bit timing comes from a baud tick supplied from outside. The block advances one bit period per tick.

While the line is released, the block watches it for an error signal from the card. The card signals a rejected character by holding the line low through the first guard bit period. When that happens, the guard period stretches by one bit time. The same character is then sent again, up to a retry limit that is captured when the character is accepted. The next character is taken from the holding interface only after the current one has finished. It finishes either because it was accepted, or because retries are off, or because the retries are used up. A one-cycle status pulse reports a character that was still rejected on its final attempt.

Top module: `sc_t0_tx`

## Requirements
- R1: After reset, `tx_ready` is 1, `line_drive_low` is 0 and `iter_exhausted` is 0.
- R2: A character accepted by `tx_valid && tx_ready` starts its start bit (line pulled low) on the first `baud_tick` after acceptance. Each later `baud_tick` moves to the next bit, in the order start, D0 to D7 (bit 0 first), parity. `line_drive_low` is 1 exactly when the bit level is 0.
- R3: The parity bit level is the XOR of the eight data bits (even parity).
- R4: `line_drive_low` is 0 in three situations: while idle, between acceptance and the first tick, and during every guard bit period.
- R5: A low `line_in` at the `baud_tick` that ends the first guard bit period is a rejection. With no rejection the guard lasts 2 bit periods. After a rejection it lasts 3 bit periods before the next attempt's start bit.
- R6: With a captured retry limit of 0, a character is sent once, whatever the card answers.
- R7: If the card rejects the first k attempts and the retry limit is M, the character is sent 1 + min(k, M) times. With a 3-bit limit this is at most 8 sends.
- R8: `iter_exhausted` is high for exactly one clock when a character ends with its last attempt rejected, including the case M = 0. It rises in the same cycle as `tx_ready`. Otherwise it stays 0.
- R9: `tx_ready` stays 0 from acceptance until the last guard bit period of the last attempt ends. Changes on `tx_data`, `tx_valid` and `max_iter` during that time have no effect on the bits sent or on the number of attempts.
- R10: The retry count starts from zero for every newly accepted character, so each character gets the full limit captured with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse marking each bit-period boundary |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | `tx_data` holds a character |
| tx_ready | output | 1 | Block is idle and takes a character this cycle |
| max_iter | input | 3 | Retry limit, captured at acceptance |
| line_in | input | 1 | Level of the shared data line, already synchronized |
| line_drive_low | output | 1 | 1 pulls the line low; 0 releases it |
| iter_exhausted | output | 1 | One-cycle pulse: character ended while still rejected |

## Verification
The assertions assume three things about the inputs. `baud_tick` is a single-cycle pulse. `line_in` is already synchronous to `clk`. The card only pulls the line low while the transmitter has released it. The stimulus keeps to these by building `line_in` as the AND of the released line and a card model. The card model pulls low only during the first guard bit period of attempts it is told to reject. Ticks are spaced two clocks apart. A sweep covers every retry limit 0 to 7 against every number of rejections 0 to 8. During each character, the bench deliberately changes the holding data, the valid signal and the retry limit.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
   typedef enum logic [1:0] {
      T0_IDLE  = 2'd0,
      T0_ALIGN = 2'd1,
      T0_FRAME = 2'd2,
      T0_GUARD = 2'd3
   } t0_phase_e;

   // start bit + data bits + parity bit
   function automatic int unsigned frame_len(input int unsigned data_bits);
      return data_bits + 2;
   endfunction
endpackage

// File: rtl/sc_t0_serializer.sv
module sc_t0_serializer
   import sc_t0_pkg::*;
#(
   parameter int unsigned DATA_BITS  = 8,
   parameter bit          ODD_PARITY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] data_in,
   input  logic                 restart,
   input  logic                 advance,
   output logic                 level,
   output logic                 at_last,
   output logic [DATA_BITS-1:0] char_q
);
   localparam int unsigned FLEN = frame_len(DATA_BITS);
   localparam int unsigned IW   = $clog2(FLEN);

   logic [IW-1:0]   idx_q;
   logic            par;
   logic [FLEN-1:0] frame;

   generate
      if (ODD_PARITY) begin : g_odd
         assign par = ~^char_q;
      end else begin : g_even
         assign par = ^char_q;
      end
   endgenerate

   assign frame   = {par, char_q, 1'b0};
   assign level   = frame[idx_q];
   assign at_last = (idx_q == IW'(FLEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q <= '0;
         idx_q  <= '0;
      end else begin
         if (load) char_q <= data_in;
         if (load || restart) idx_q <= '0;
         else if (advance)    idx_q <= idx_q + IW'(1);
      end
   end

   // R2: the bit index never runs past the parity bit
   p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= IW'(FLEN - 1));
endmodule

// File: rtl/sc_t0_retry.sv
module sc_t0_retry #(
   parameter int unsigned ITER_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ITER_W-1:0] max_in,
   input  logic              done,
   input  logic              nacked,
   output logic              again,
   output logic              give_up
);
   logic [ITER_W-1:0] max_q;
   logic [ITER_W-1:0] cnt_q;

   assign again   = nacked && (cnt_q < max_q);
   assign give_up = done && nacked && !again;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         max_q <= '0;
         cnt_q <= '0;
      end else if (start) begin
         max_q <= max_in;      // R9: limit captured once per character
         cnt_q <= '0;          // R10: fresh count per character
      end else if (done && again) begin
         cnt_q <= cnt_q + ITER_W'(1);
      end
   end

   // R7: repetitions never exceed the captured limit
   p_rep_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= max_q);
endmodule

// File: rtl/sc_t0_tx.sv
module sc_t0_tx
   import sc_t0_pkg::*;
#(
   parameter int unsigned DATA_BITS  = 8,
   parameter int unsigned GUARD_BITS = 2,
   parameter int unsigned ITER_W     = 3,
   parameter bit          ODD_PARITY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 baud_tick,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   input  logic [ITER_W-1:0]    max_iter,
   input  logic                 line_in,
   output logic                 line_drive_low,
   output logic                 iter_exhausted
);
   localparam int unsigned GW = $clog2(GUARD_BITS + 2);

   generate
      if (GUARD_BITS < 2) begin : g_bad_guard
         $error("GUARD_BITS must be at least 2");
      end
      if (DATA_BITS < 1) begin : g_bad_data
         $error("DATA_BITS must be at least 1");
      end
      if (ITER_W < 1 || ITER_W > 3) begin : g_bad_iter
         $error("ITER_W must be 1..3 (at most eight sends)");
      end
   endgenerate

   t0_phase_e            phase_q;
   logic [GW-1:0]        gcnt_q;
   logic                 nack_q;
   logic                 exh_q;
   logic                 level, at_last;
   logic [DATA_BITS-1:0] char_q;
   logic                 accept, nack_now, nack_eff, guard_last;
   logic                 attempt_done, frame_adv, restart, again, give_up;

   assign tx_ready       = (phase_q == T0_IDLE);
   assign accept         = tx_ready && tx_valid;
   assign nack_now       = (phase_q == T0_GUARD) && baud_tick && (gcnt_q == '0) && !line_in;
   assign nack_eff       = nack_q || nack_now;
   assign guard_last     = (gcnt_q == (nack_eff ? GW'(GUARD_BITS) : GW'(GUARD_BITS - 1)));
   assign attempt_done   = (phase_q == T0_GUARD) && baud_tick && guard_last;
   assign frame_adv      = (phase_q == T0_FRAME) && baud_tick && !at_last;
   assign restart        = attempt_done && again;
   assign line_drive_low = (phase_q == T0_FRAME) && !level;
   assign iter_exhausted = exh_q;

   sc_t0_serializer #(.DATA_BITS(DATA_BITS), .ODD_PARITY(ODD_PARITY)) i_ser (
      .clk(clk), .rst_n(rst_n), .load(accept), .data_in(tx_data),
      .restart(restart), .advance(frame_adv),
      .level(level), .at_last(at_last), .char_q(char_q)
   );

   sc_t0_retry #(.ITER_W(ITER_W)) i_retry (
      .clk(clk), .rst_n(rst_n), .start(accept), .max_in(max_iter),
      .done(attempt_done), .nacked(nack_eff),
      .again(again), .give_up(give_up)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= T0_IDLE;
         gcnt_q  <= '0;
         nack_q  <= 1'b0;
         exh_q   <= 1'b0;
      end else begin
         exh_q <= give_up;
         unique case (phase_q)
            T0_IDLE:  if (accept) phase_q <= T0_ALIGN;
            T0_ALIGN: if (baud_tick) phase_q <= T0_FRAME;
            T0_FRAME: if (baud_tick && at_last) begin
               phase_q <= T0_GUARD;
               gcnt_q  <= '0;
               nack_q  <= 1'b0;
            end
            T0_GUARD: if (baud_tick) begin
               nack_q <= nack_eff;
               if (guard_last) phase_q <= again ? T0_FRAME : T0_IDLE;
               else            gcnt_q  <= gcnt_q + GW'(1);
            end
            default: phase_q <= T0_IDLE;
         endcase
      end
   end

   // R8: the exhausted pulse lasts a single clock
   p_exh_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iter_exhausted |=> !iter_exhausted);
   // R8: the pulse coincides with the end of the character
   p_exh_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      iter_exhausted |-> tx_ready);
   // R9: the character under transmission is held through all attempts
   p_char_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready && $past(!tx_ready)) |-> $stable(char_q));
   // R5: the guard counter stays within the stretched guard length
   p_guard_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == T0_GUARD) |-> (gcnt_q <= GW'(GUARD_BITS)));
   // R4: nothing is pulled low while the block is idle
   p_idle_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> !line_drive_low);
endmodule

// File: tb/test_sc_t0_tx.sv
module test_sc_t0_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [2:0] max_iter = '0;
   logic       line_in;
   logic       line_drive_low;
   logic       iter_exhausted;
   logic       card_pull = 1'b0;
   int         tests = 0;
   int         fails = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   assign line_in = !(line_drive_low || card_pull);

   sc_t0_tx i_sc_t0_tx (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_data(tx_data),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .max_iter(max_iter),
      .line_in(line_in), .line_drive_low(line_drive_low),
      .iter_exhausted(iter_exhausted)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
   endtask

   // m: retry limit, k: number of leading attempts the card rejects
   task automatic send_char(input logic [7:0] d, input int m, input int k);
      int         attempts;
      bit         exh;
      logic [9:0] lv;
      attempts = 1 + ((k < m) ? k : m);
      exh      = (k > m);
      lv       = {^d, d, 1'b0};
      @(negedge clk);
      chk(tx_ready == 1'b1, "R9", tx_ready, 1);
      tx_data = d; tx_valid = 1'b1; max_iter = 3'(m);
      @(negedge clk);
      chk(tx_ready == 1'b0, "R9", tx_ready, 0);
      // decoys held during the character (R9)
      tx_data = ~d; max_iter = 3'(7 - m);
      chk(line_drive_low == 1'b0, "R4", line_drive_low, 0);
      for (int a = 0; a < attempts; a++) begin
         bit nk;
         int lim;
         nk = (a < k);
         for (int b = 0; b < 10; b++) begin
            tick();
            chk(line_drive_low == !lv[b], (b == 9) ? "R3" : "R2", line_drive_low, !lv[b]);
         end
         tick();   // first guard bit
         chk(line_drive_low == 1'b0, "R4", line_drive_low, 0);
         card_pull = nk;
         lim = 2 + int'(nk);
         for (int g = 1; g < lim; g++) begin
            tick();
            card_pull = 1'b0;
            chk(line_drive_low == 1'b0 && tx_ready == 1'b0, "R5",
                {line_drive_low, tx_ready}, 0);
         end
      end
      tick();   // end of last guard period
      tx_valid = 1'b0;
      chk(tx_ready == 1'b1, (m == 0) ? "R6" : "R7 R10", tx_ready, 1);
      chk(iter_exhausted == exh, "R8", iter_exhausted, exh);
      chk(line_drive_low == 1'b0, "R4", line_drive_low, 0);
      @(negedge clk);
      chk(iter_exhausted == 1'b0, "R8", iter_exhausted, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(tx_ready == 1'b1 && line_drive_low == 1'b0 && iter_exhausted == 1'b0,
          "R1", {tx_ready, line_drive_low, iter_exhausted}, 4);
      rst_n = 1'b1;
      @(negedge clk);
      chk(tx_ready == 1'b1 && line_drive_low == 1'b0, "R1", {tx_ready, line_drive_low}, 2);
      for (int i = 0; i < 3; i++) begin
         tick();
         chk(line_drive_low == 1'b0 && tx_ready == 1'b1, "R4", {line_drive_low, tx_ready}, 1);
      end
      for (int m = 0; m < 8; m++) begin
         for (int k = 0; k < 9; k++) begin
            send_char(8'(m * 37 + k * 11 + 5), m, k);
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule